// File: doc/BRIEF.md
# RV32 Integer and Multiply ALU

This block is the arithmetic core of a single-cycle RV32 datapath. It takes two 32-bit operands and a 4-bit operation code and returns one 32-bit result within the same cycle. It has no clock, no reset and no internal state.

Every operation is computed in parallel from the operands. A multiplexer keyed on the operation code then picks one of these results. The operation set covers the following:

- add and subtract
- the three bitwise logic operations
- the three shifts
- signed set-less-than
- a pass-through of the second operand
- three multiply variants, which return either half of the 64-bit product

The operation codes are fixed and sparse. Three of them are unused and produce zero.

Top module: `rv_alu_core`

## Requirements
- R1: Code 0 (add) gives (A + B) mod 2^32, with no overflow indication.
- R2: Code 12 (sub) gives (A - B) mod 2^32.
- R3: Code 2 (slt) gives 32'd1 when A < B as two's-complement numbers and 32'd0 otherwise, so bits 31..1 are always zero.
- R4: Codes 4 (xor), 6 (or) and 7 (and) give the bitwise function of A and B.
- R5: Code 1 (sll) shifts A left by B[4:0], filling with zeros. B[31:5] has no effect, and an amount of 0 returns A.
- R6: Code 5 (srl) shifts A right by B[4:0] with zero fill, so an amount of 31 leaves only A[31] in bit 0.
- R7: Code 13 (sra) shifts A right by B[4:0], filling with copies of A[31].
- R8: Code 8 (mul) gives bits 31..0 of the product A*B.
- R9: Code 9 (mulh) gives bits 63..32 of the signed-by-signed 64-bit product.
- R10: Code 11 (mulhu) gives bits 63..32 of the unsigned-by-unsigned 64-bit product.
- R11: Code 15 gives B unchanged, whatever the value of A.
- R12: Codes 3, 10 and 14 give 32'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; its low 5 bits are the shift amount |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Selected operation result |

## Verification
The checker's immediate assertions assume that the operands and the operation code are fully known (not X or Z). Each check is guarded so that it evaluates only once all of its inputs are known. The bench drives only known values.

The random stimulus draws the operation code from all sixteen values, including the unused ones, and draws the operands over the full 32-bit range. Directed passes pair the extreme operand values with each code. They also drive shift amounts of 0 and 31 with the upper bits of B set, so that the properties on the shift boundaries and on the unused codes are actually reached.

// File: rtl/rv_alu_pkg.sv
`timescale 1ns/1ps
package rv_alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SLL   = 4'd1,
        OP_SLT   = 4'd2,
        OP_XOR   = 4'd4,
        OP_SRL   = 4'd5,
        OP_OR    = 4'd6,
        OP_AND   = 4'd7,
        OP_MUL   = 4'd8,
        OP_MULH  = 4'd9,
        OP_MULHU = 4'd11,
        OP_SUB   = 4'd12,
        OP_SRA   = 4'd13,
        OP_PASSB = 4'd15
    } alu_op_e;
endpackage

// File: rtl/rv_alu_addsub.sv
`timescale 1ns/1ps
module rv_alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] diff_o,
    output logic              lt_signed_o
);
    always_comb begin
        sum_o       = a_i + b_i;
        diff_o      = a_i - b_i;
        lt_signed_o = $signed(a_i) < $signed(b_i);
    end
endmodule

// File: rtl/rv_alu_shift.sv
`timescale 1ns/1ps
module rv_alu_shift #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [DATA_W-1:0]  sll_o,
    output logic [DATA_W-1:0]  srl_o,
    output logic [DATA_W-1:0]  sra_o
);
    always_comb begin
        sll_o = a_i << amt_i;
        srl_o = a_i >> amt_i;
        sra_o = DATA_W'($signed(a_i) >>> amt_i);
    end
endmodule

// File: rtl/rv_alu_mult.sv
`timescale 1ns/1ps
module rv_alu_mult #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_ss_o,
    output logic [DATA_W-1:0] hi_uu_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] a_ext;
    logic [PROD_W-1:0] b_ext;
    logic [PROD_W-1:0] prod_ss;
    logic [DATA_W-1:0] corr_a;
    logic [DATA_W-1:0] corr_b;

    always_comb begin
        // One signed array; the unsigned high half is recovered by correction.
        a_ext   = {{DATA_W{a_i[DATA_W-1]}}, a_i};
        b_ext   = {{DATA_W{b_i[DATA_W-1]}}, b_i};
        prod_ss = a_ext * b_ext;
        corr_a  = a_i[DATA_W-1] ? b_i : '0;
        corr_b  = b_i[DATA_W-1] ? a_i : '0;
        lo_o    = prod_ss[DATA_W-1:0];
        hi_ss_o = prod_ss[PROD_W-1:DATA_W];
        hi_uu_o = hi_ss_o + corr_a + corr_b;
    end
endmodule

// File: rtl/rv_alu_core.sv
`timescale 1ns/1ps
module rv_alu_core
    import rv_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [OP_W-1:0]   op_sel,
    output logic [DATA_W-1:0] result
);
    localparam int SHAMT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sum_w, diff_w;
    logic              lt_w;
    logic [DATA_W-1:0] sll_w, srl_w, sra_w;
    logic [DATA_W-1:0] mlo_w, mhs_w, mhu_w;
    logic [DATA_W-1:0] result_d;

    rv_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i        (opnd_a),
        .b_i        (opnd_b),
        .sum_o      (sum_w),
        .diff_o     (diff_w),
        .lt_signed_o(lt_w)
    );

    rv_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .a_i  (opnd_a),
        .amt_i(opnd_b[SHAMT_W-1:0]),
        .sll_o(sll_w),
        .srl_o(srl_w),
        .sra_o(sra_w)
    );

    rv_alu_mult #(.DATA_W(DATA_W)) u_mult (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .lo_o   (mlo_w),
        .hi_ss_o(mhs_w),
        .hi_uu_o(mhu_w)
    );

    always_comb begin
        case (op_sel)
            OP_ADD:   result_d = sum_w;
            OP_SUB:   result_d = diff_w;
            OP_SLT:   result_d = {{(DATA_W-1){1'b0}}, lt_w};
            OP_XOR:   result_d = opnd_a ^ opnd_b;
            OP_OR:    result_d = opnd_a | opnd_b;
            OP_AND:   result_d = opnd_a & opnd_b;
            OP_SLL:   result_d = sll_w;
            OP_SRL:   result_d = srl_w;
            OP_SRA:   result_d = sra_w;
            OP_MUL:   result_d = mlo_w;
            OP_MULH:  result_d = mhs_w;
            OP_MULHU: result_d = mhu_w;
            OP_PASSB: result_d = opnd_b;
            default:  result_d = '0;
        endcase
    end

    assign result = result_d;
endmodule

// File: rtl/rv_alu_core_chk.sv
`timescale 1ns/1ps
module rv_alu_core_chk #(
    parameter int DATA_W = 32
) (
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] result
);
    localparam int SHAMT_W = $clog2(DATA_W);

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            if (op_sel == 4'd15)
                p_passb_r11: assert (result == opnd_b)
                    else $error("pass-through differs from B");
            if (op_sel == 4'd3 || op_sel == 4'd10 || op_sel == 4'd14)
                p_unused_zero_r12: assert (result == '0)
                    else $error("unused code gave nonzero");
            if (op_sel == 4'd2)
                p_slt_bool_r3: assert (result[DATA_W-1:1] == '0)
                    else $error("slt upper bits set");
            if ((op_sel == 4'd1 || op_sel == 4'd5 || op_sel == 4'd13) && opnd_b[SHAMT_W-1:0] == '0)
                p_shift_zero_r5: assert (result == opnd_a)
                    else $error("zero shift altered A");
            if (op_sel == 4'd5 && opnd_b[SHAMT_W-1:0] == SHAMT_W'(DATA_W-1))
                p_srl_fill_r6: assert (result == DATA_W'(opnd_a[DATA_W-1]))
                    else $error("srl fill wrong");
            if (op_sel == 4'd13 && opnd_b[SHAMT_W-1:0] == SHAMT_W'(DATA_W-1))
                p_sra_fill_r7: assert (result == {DATA_W{opnd_a[DATA_W-1]}})
                    else $error("sra fill wrong");
        end
    end
endmodule

bind rv_alu_core rv_alu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .opnd_a(opnd_a),
    .opnd_b(opnd_b),
    .op_sel(op_sel),
    .result(result)
);

// File: tb/tb_rv_alu_core.sv
`timescale 1ns/1ps
module tb_rv_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [3:0]  sel;
    logic [31:0] res;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    rv_alu_core dut (.opnd_a(a), .opnd_b(b), .op_sel(sel), .result(res));

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y, input logic [3:0] s);
        longint      sp;
        logic [63:0] up;
        int          sh;
        sh = int'(y[4:0]);
        sp = longint'($signed(x)) * longint'($signed(y));
        up = {32'd0, x} * {32'd0, y};
        case (s)
            4'd0:  return x + y;
            4'd12: return x - y;
            4'd2:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            4'd4:  return x ^ y;
            4'd6:  return x | y;
            4'd7:  return x & y;
            4'd1:  return x << sh;
            4'd5:  return x >> sh;
            4'd13: return 32'($signed(x) >>> sh);
            4'd8:  return up[31:0];
            4'd9:  return sp[63:32];
            4'd11: return up[63:32];
            4'd15: return y;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] s);
        case (s)
            4'd0:  return "R1";
            4'd12: return "R2";
            4'd2:  return "R3";
            4'd4, 4'd6, 4'd7: return "R4";
            4'd1:  return "R5";
            4'd5:  return "R6";
            4'd13: return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd11: return "R10";
            4'd15: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] s);
        logic [31:0] exp;
        @(posedge clk);
        a = x; b = y; sel = s;
        exp = model(x, y, s);
        @(negedge clk);
        n_vec++;
        if (res !== exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d a=%h b=%h actual=%h expected=%h", tag(s), s, x, y, res, exp);
        end
    endtask

    initial begin
        logic [31:0] corners [5];
        corners = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h1};
        a = '0; b = '0; sel = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state check: all-zero inputs on add (R1) yield zero
        apply(32'h0, 32'h0, 4'd0);
        // Corner operands on every code, R1..R12
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int s = 0; s < 16; s++)
                    apply(corners[i], corners[j], 4'(s));
        // Shift amounts 0 and 31 with upper B bits set (R5 R6 R7)
        foreach (corners[i]) begin
            apply(corners[i], 32'hFFFF_FFE0, 4'd1);
            apply(corners[i], 32'hFFFF_FFE0, 4'd5);
            apply(corners[i], 32'hFFFF_FFE0, 4'd13);
            apply(corners[i], 32'hABCD_EF1F, 4'd1);
            apply(corners[i], 32'hABCD_EF1F, 4'd5);
            apply(corners[i], 32'hABCD_EF1F, 4'd13);
        end
        // Pass-through of B independent of A (R11)
        apply(32'hDEAD_BEEF, 32'h1234_5678, 4'd15);
        apply(32'h0, 32'h1234_5678, 4'd15);
        // Random mix over all codes
        for (int k = 0; k < 3000; k++)
            apply($urandom, $urandom, 4'($urandom));
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule